// File: doc/BRIEF.md
# Fixed-Point Exception Reporter

This block is the last stage of a fixed-point execution unit. For every completed operation it receives the operation class, the untruncated result from the datapath, a quotient-too-large indication from the divider, the packed decimal source operand of a convert-to-binary, and the program mask bit that enables overflow interrupts. One clock later it presents the register write-back (value and enable), the condition-code update, and, when an exception is detected, an interrupt request with a cause code and a one-cycle pulse that sets the matching bit in the interrupt flag register.

An overflow still completes the operation. The block writes the low 32 bits of the result and sets condition code 3. The mask bit only decides whether the interrupt and the flag bit are raised. Divide errors and data errors are different: they suppress the operation, so nothing is written and the condition code is left alone. They are always reported.

Top module: `fxp_exc_report`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the cycle after that edge, all outputs are zero.
- R2: The classes sign control (0), add (1), subtract (2) and shift (3) overflow when `wide_res`, read as a signed 64-bit value, lies outside [-2^31, 2^31-1]. On overflow the block asserts `wb_en` with `wb_data` equal to bits 31:0 of `wide_res`, and asserts `cc_upd` with `cc_val` = 3.
- R3: On an R2 overflow with `fxo_mask` = 1, `irq_req` and `flag_set` are both asserted with `irq_cause` = 1. With `fxo_mask` = 0 neither is asserted.
- R4: A class 0–3 result with no overflow writes bits 31:0 with `cc_upd` asserted. `cc_val` is 0 for a zero result, 1 for a negative result and 2 for a positive result. No interrupt is raised.
- R5: Divide (class 4) with `div_ovf` = 1 suppresses the operation, so `wb_en` and `cc_upd` are low. It raises `irq_req` with `irq_cause` = 2. Otherwise the quotient (bits 31:0) is written, with no condition-code update and no interrupt.
- R6: Convert-to-binary (class 5) with a valid operand raises a divide error when its result needs more than 31 bits of magnitude, that is, when `wide_res` is outside [-(2^31-1), 2^31-1]. The error has cause 2 and the write is suppressed. Otherwise bits 31:0 are written with no condition-code update.
- R7: Convert-to-binary with an invalid decimal operand raises a data error with cause 3 and suppresses the write and the condition code. The data error takes precedence over R6.
- R8: The decimal operand holds seven digit nibbles in bits 31:4 and a sign nibble in bits 3:0. A digit is valid when its value is 0–9. A sign is valid when its value is A–F.
- R9: `fxo_mask` has no effect on divide errors or data errors. Those are reported whatever its value.
- R10: Outputs follow the inputs one clock later. `flag_set` is asserted exactly when `irq_req` is. When `op_valid` is low, or the class is 6 or 7, all outputs are zero in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation result is presented this cycle |
| op_cls | input | 3 | Class: 0 sign, 1 add, 2 sub, 3 shift, 4 divide, 5 convert-to-binary |
| wide_res | input | 64 | Untruncated signed result from the datapath |
| div_ovf | input | 1 | Quotient does not fit the register (divide only) |
| dec_operand | input | 32 | Packed decimal source of convert-to-binary |
| fxo_mask | input | 1 | Program mask bit enabling overflow interrupts |
| wb_en | output | 1 | Register write enable |
| wb_data | output | 32 | Value to write back |
| cc_upd | output | 1 | Condition-code update enable |
| cc_val | output | 2 | New condition code |
| irq_req | output | 1 | Interrupt request |
| irq_cause | output | 2 | 1 overflow, 2 divide error, 3 data error |
| flag_set | output | 1 | One-cycle set pulse for the interrupt flag bit |

## Verification
Two situations are the hardest to reach from the ports. The first is a convert-to-binary where a bad decimal operand coincides with an oversized magnitude, which decides R7 precedence. The second is the exact edges of the two ranges: -2^31 is legal for arithmetic but a divide error for conversion. Uniform random 64-bit values almost never land there. The stimulus therefore draws results from a weighted mix that includes a table of boundary values. It also injects invalid nibbles at random positions of otherwise valid operands, and directed cases pair each boundary with an invalid operand and with both mask values.

// File: rtl/fxp_exc_pkg.sv
// Package: shared encodings of the fixed-point exception reporter.
// Assumes the 3-bit class field and 2-bit cause / condition-code fields.
package fxp_exc_pkg;
    typedef enum logic [2:0] {
        OP_SIGN  = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_SHIFT = 3'd3,
        OP_DIV   = 3'd4,
        OP_CVB   = 3'd5
    } op_cls_e;

    localparam logic [1:0] CAUSE_NONE = 2'd0;
    localparam logic [1:0] CAUSE_OVF  = 2'd1;
    localparam logic [1:0] CAUSE_DIV  = 2'd2;
    localparam logic [1:0] CAUSE_DATA = 2'd3;

    localparam logic [1:0] CC_ZERO = 2'd0;
    localparam logic [1:0] CC_NEG  = 2'd1;
    localparam logic [1:0] CC_POS  = 2'd2;
    localparam logic [1:0] CC_OVF  = 2'd3;
endpackage

// File: rtl/fxp_dec_check.sv
// Module: validity check of a packed decimal operand.
// Assumes DIGITS digit nibbles above a sign nibble in bits 3:0.
// Digits must be 0-9 and the sign must be A-F. Purely combinational.
module fxp_dec_check #(
    parameter int DIGITS = 7,
    localparam int DEC_W = 4 * (DIGITS + 1)
) (
    input  logic [DEC_W-1:0] dec_in,
    output logic             dec_ok
);
    logic [DIGITS-1:0] dig_ok;
    logic              sign_ok;

    // One comparator per digit nibble.
    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        assign dig_ok[g] = (dec_in[4*(g+1) +: 4] <= 4'd9);
    end

    // Sign nibble accepted in the range A through F.
    assign sign_ok = (dec_in[3:0] >= 4'hA);
    assign dec_ok  = (&dig_ok) && sign_ok;
endmodule

// File: rtl/fxp_range_check.sv
// Module: range tests on the untruncated signed result.
// fits_word: value fits a DATA_W-bit two's complement register.
// fits_mag : value additionally has magnitude at most 2^(DATA_W-1)-1.
// Assumes WIDE_W > DATA_W. Purely combinational.
module fxp_range_check #(
    parameter int DATA_W = 32,
    parameter int WIDE_W = 64,
    localparam int TOP_W = WIDE_W - DATA_W + 1
) (
    input  logic [WIDE_W-1:0] wide_in,
    output logic              fits_word,
    output logic              fits_mag
);
    logic [TOP_W-1:0] top_bits;
    logic             most_neg;

    // Bits above the kept sign must replicate it.
    assign top_bits  = wide_in[WIDE_W-1 -: TOP_W];
    assign fits_word = (top_bits == '0) || (top_bits == '1);

    // The single in-range value whose magnitude needs DATA_W bits.
    assign most_neg  = wide_in[WIDE_W-1] && (wide_in[DATA_W-2:0] == '0);
    assign fits_mag  = fits_word && !most_neg;
endmodule

// File: rtl/fxp_exc_report.sv
// Module: result-stage exception reporter of a fixed-point unit.
// Classifies each completed operation (overflow, divide error, data error),
// decides write-back and condition code, and raises an interrupt with cause.
// Assumes one operation per cycle at most; outputs registered, latency 1.
module fxp_exc_report
    import fxp_exc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int WIDE_W     = 64,
    parameter int DEC_DIGITS = 7,
    localparam int DEC_W     = 4 * (DEC_DIGITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_cls,
    input  logic [WIDE_W-1:0] wide_res,
    input  logic              div_ovf,
    input  logic [DEC_W-1:0]  dec_operand,
    input  logic              fxo_mask,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_data,
    output logic              cc_upd,
    output logic [1:0]        cc_val,
    output logic              irq_req,
    output logic [1:0]        irq_cause,
    output logic              flag_set
);
    logic              fits_word, fits_mag, dec_ok;
    logic [DATA_W-1:0] trunc;
    logic              n_wb, n_cc_upd, n_irq;
    logic [1:0]        n_cc, n_cause;

    fxp_range_check #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_rng (
        .wide_in  (wide_res),
        .fits_word(fits_word),
        .fits_mag (fits_mag)
    );

    fxp_dec_check #(.DIGITS(DEC_DIGITS)) u_dec (
        .dec_in(dec_operand),
        .dec_ok(dec_ok)
    );

    assign trunc = wide_res[DATA_W-1:0];

    // Decide write-back, condition code and exception for this operation.
    always_comb begin
        n_wb     = 1'b0;
        n_cc_upd = 1'b0;
        n_cc     = CC_ZERO;
        n_irq    = 1'b0;
        n_cause  = CAUSE_NONE;
        if (op_valid) begin
            case (op_cls)
                OP_SIGN, OP_ADD, OP_SUB, OP_SHIFT: begin
                    n_wb     = 1'b1;
                    n_cc_upd = 1'b1;
                    if (!fits_word) begin
                        n_cc = CC_OVF;
                        if (fxo_mask) begin
                            n_irq   = 1'b1;
                            n_cause = CAUSE_OVF;
                        end
                    end else if (trunc == '0) begin
                        n_cc = CC_ZERO;
                    end else if (trunc[DATA_W-1]) begin
                        n_cc = CC_NEG;
                    end else begin
                        n_cc = CC_POS;
                    end
                end
                OP_DIV: begin
                    if (div_ovf) begin
                        n_irq   = 1'b1;
                        n_cause = CAUSE_DIV;
                    end else begin
                        n_wb = 1'b1;
                    end
                end
                OP_CVB: begin
                    if (!dec_ok) begin
                        n_irq   = 1'b1;
                        n_cause = CAUSE_DATA;
                    end else if (!fits_mag) begin
                        n_irq   = 1'b1;
                        n_cause = CAUSE_DIV;
                    end else begin
                        n_wb = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Register the result-stage outputs; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en     <= 1'b0;
            wb_data   <= '0;
            cc_upd    <= 1'b0;
            cc_val    <= CC_ZERO;
            irq_req   <= 1'b0;
            irq_cause <= CAUSE_NONE;
            flag_set  <= 1'b0;
        end else begin
            wb_en     <= n_wb;
            wb_data   <= n_wb ? trunc : '0;
            cc_upd    <= n_cc_upd;
            cc_val    <= n_cc;
            irq_req   <= n_irq;
            irq_cause <= n_cause;
            flag_set  <= n_irq;
        end
    end

    AST_SUPPRESS_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_cause != CAUSE_OVF) |-> (!wb_en && !cc_upd)); // R5
    AST_OVF_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_cause == CAUSE_OVF) |-> (wb_en && cc_upd && cc_val == CC_OVF)); // R2
    AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set == irq_req); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(op_valid) |-> (!wb_en && !cc_upd && !irq_req)); // R10
    AST_DATA_ERR_CVB: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_cause == CAUSE_DATA) |-> $past(op_cls == OP_CVB && !dec_ok)); // R7
    AST_MASKED_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_cause == CAUSE_OVF) |-> $past(fxo_mask)); // R3
endmodule

// File: tb/sim_fxp_exc_report.sv
module sim_fxp_exc_report;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_cls = '0;
    logic [63:0] wide_res = '0;
    logic        div_ovf = 1'b0;
    logic [31:0] dec_operand = '0;
    logic        fxo_mask = 1'b0;
    logic        wb_en, cc_upd, irq_req, flag_set;
    logic [31:0] wb_data;
    logic [1:0]  cc_val, irq_cause;
    int          n_run = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    fxp_exc_report u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cls(op_cls),
        .wide_res(wide_res), .div_ovf(div_ovf), .dec_operand(dec_operand),
        .fxo_mask(fxo_mask), .wb_en(wb_en), .wb_data(wb_data), .cc_upd(cc_upd),
        .cc_val(cc_val), .irq_req(irq_req), .irq_cause(irq_cause), .flag_set(flag_set)
    );

    // Expected output vector {wb, data, ccu, cc, irq, cause, flag}, from the requirements.
    function automatic logic [39:0] model(bit v, logic [2:0] c, logic [63:0] w,
                                          bit dov, logic [31:0] d, bit m);
        longint s = w;
        bit wb = 0, ccu = 0, irq = 0, dok = 1;
        logic [1:0] cc = 0, cause = 0;
        logic [31:0] lo = w[31:0];
        for (int i = 1; i < 8; i++) if (d[4*i +: 4] > 4'd9) dok = 0;
        if (d[3:0] < 4'hA) dok = 0;
        if (v) begin
            if (c <= 3'd3) begin
                wb = 1; ccu = 1;
                if (s > 64'sd2147483647 || s < -64'sd2147483648) begin
                    cc = 3; if (m) begin irq = 1; cause = 1; end
                end else cc = (lo == 0) ? 2'd0 : (lo[31] ? 2'd1 : 2'd2);
            end else if (c == 3'd4) begin
                if (dov) begin irq = 1; cause = 2; end else wb = 1;
            end else if (c == 3'd5) begin
                if (!dok) begin irq = 1; cause = 3; end
                else if (s > 64'sd2147483647 || s < -64'sd2147483647) begin irq = 1; cause = 2; end
                else wb = 1;
            end
        end
        return {wb, wb ? lo : 32'd0, ccu, ccu ? cc : 2'd0, irq, irq ? cause : 2'd0, irq};
    endfunction

    function automatic string tag_of(bit v, logic [2:0] c, logic [39:0] e);
        if (!v || c > 3'd5) return "R10";
        if (c <= 3'd3) return e[3] ? "R3" : (e[6] ? "R2" : "R4");
        if (c == 3'd4) return e[3] ? "R5/R9" : "R5";
        if (e[2:1] == 2'd3) return "R7/R8/R9";
        return "R6";
    endfunction

    task automatic check(string tag, logic [39:0] exp);
        logic [39:0] act;
        act = {wb_en, wb_en ? wb_data : 32'd0, cc_upd, cc_upd ? cc_val : 2'd0,
               irq_req, irq_req ? irq_cause : 2'd0, flag_set};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(bit v, logic [2:0] c, logic [63:0] w, bit dov, logic [31:0] d, bit m);
        logic [39:0] e;
        @(negedge clk);
        op_valid = v; op_cls = c; wide_res = w; div_ovf = dov; dec_operand = d; fxo_mask = m;
        e = model(v, c, w, dov, d, m);
        @(posedge clk); #1;
        check(tag_of(v, c, e), e);
    endtask

    function automatic logic [63:0] pick_wide();
        logic [63:0] b;
        case ($urandom % 4)
            0: return {{48{1'b0}}, 16'($urandom)} - 64'd32768;
            1: begin
                case ($urandom % 7)
                    0: b = 64'd2147483647;
                    1: b = 64'd2147483648;
                    2: b = -64'd2147483648;
                    3: b = -64'd2147483649;
                    4: b = 64'd0;
                    5: b = -64'd1;
                    default: b = -64'd2147483647;
                endcase
                return b;
            end
            2: return {32'($urandom), 32'($urandom)};
            default: begin b[31:0] = $urandom; return {{32{b[31]}}, b[31:0]}; end
        endcase
    endfunction

    function automatic logic [31:0] pick_dec();
        logic [31:0] d;
        for (int i = 1; i < 8; i++) d[4*i +: 4] = 4'($urandom % 10);
        d[3:0] = 4'(10 + $urandom % 6);
        if ($urandom % 5 == 0) begin
            int k = $urandom % 8;
            d[4*k +: 4] = (k == 0) ? 4'($urandom % 10) : 4'(10 + $urandom % 6);
        end
        return d;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset with valid inputs present must keep outputs zero.
        @(negedge clk);
        op_valid = 1; op_cls = 3'd1; wide_res = 64'd1 << 40; fxo_mask = 1;
        @(posedge clk); #1;
        check("R1", 40'd0);
        @(posedge clk); #1;
        check("R1", 40'd0);
        @(negedge clk); rst_n = 1; op_valid = 0;
        // Directed corner cases.
        run_op(1, 3'd1, 64'd2147483648, 0, 32'h0000000C, 1);   // R2 R3 overflow, masked in
        run_op(0, 3'd0, 64'd0, 0, 32'h0000000C, 0);            // R10 pulse ends
        run_op(1, 3'd2, -64'd2147483649, 0, 32'h0000000C, 0);  // R3 mask clear
        run_op(1, 3'd3, -64'd2147483648, 0, 32'h0000000C, 1);  // R4 edge fits
        run_op(1, 3'd0, 64'd0, 0, 32'h0000000C, 1);            // R4 zero
        run_op(1, 3'd4, 64'd5, 1, 32'h0000000C, 0);            // R5 R9 unmasked divide error
        run_op(1, 3'd4, 64'd5, 0, 32'h0000000C, 0);            // R5 normal quotient
        run_op(1, 3'd5, -64'd2147483648, 0, 32'h1234567D, 0);  // R6 magnitude edge
        run_op(1, 3'd5, -64'd2147483647, 0, 32'h1234567D, 0);  // R6 legal edge
        run_op(1, 3'd5, 64'd1 << 40, 0, 32'h12A4567C, 0);      // R7 precedence, R8 bad digit
        run_op(1, 3'd5, 64'd7, 0, 32'h12345679, 0);            // R8 bad sign
        run_op(1, 3'd6, 64'd1 << 40, 1, 32'h00000000, 1);      // R10 unused class
        run_op(1, 3'd7, 64'd3, 0, 32'h0000000C, 1);            // R10 unused class
        // Constrained random mix.
        for (int n = 0; n < 2000; n++) begin
            bit v = ($urandom % 5) != 0;
            logic [2:0] c = ($urandom % 10 == 0) ? 3'(6 + $urandom % 2) : 3'($urandom % 6);
            run_op(v, c, pick_wide(), 1'($urandom), pick_dec(), 1'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule